// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of an I/O-mapped peripheral. It presents two byte-wide ports: writing the lower address (the index port) chooses a configuration register, and accessing the next address (the data port) reads or writes that register. The port starts locked. It opens only after a fixed key byte arrives at the index port twice in a row, and a second key closes it again.

With the port open, index 0x07 holds a logical-device number. Indices at or above a window base belong to the chosen logical device. For those accesses the block raises a one-cycle read or write strobe, together with the device number and the register index, toward the device register files. A few global indices return fixed identity values: a device code, a manufacturer code and a revision byte. The identity values, the base address (normally 0x2E or 0x4E) and the window base are parameters.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is locked, `dev_sel` is 0, and a data-port read returns 0xFF.
- R2: While locked, every data-port read returns 0xFF with no strobe, and data-port writes change nothing: `dev_sel` is unchanged and `dev_wr` stays low.
- R3: Writing 0x87 to the index port on two consecutive index writes opens the port.
- R4: While locked, an index write of any value other than 0x87 restarts the key sequence, so a single 0x87 that follows it does not open the port.
- R5: Writing 0xAA to the index port while open locks the port again; later data reads return 0xFF.
- R6: While open, any other index write stores that byte as the current register index, driven on `dev_reg`, and an index-port read returns it.
- R7: A data write with index 0x07 loads `dev_sel`, and a data read at index 0x07 returns that value.
- R8: Data reads at indices 0x20 and 0x21 return the high and low bytes of the device code. Index 0x22 returns the revision byte. Indices 0x23 and 0x24 return the high and low bytes of the manufacturer code.
- R9: While open, with the index at or above `WIN_BASE` (0x30 by default), a data write raises `dev_wr` for the access cycle with `dev_wdata` equal to the written byte. A data read raises `dev_rd` and returns `dev_rdata`. The strobes never rise for lower indices.
- R10: Accesses whose address is neither the base nor base+1 change no state.
- R11: Data reads at global indices below `WIN_BASE` other than 0x07 and 0x20–0x24 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write cycle, one clock per access |
| io_rd | input | 1 | Read cycle, one clock per access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational |
| dev_sel | output | 8 | Selected logical device number |
| dev_reg | output | 8 | Current register index |
| dev_wdata | output | 8 | Byte toward the device register file |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_rdata | input | 8 | Byte returned by the selected device |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle and that each access lasts exactly one clock. The bench raises one strobe for a single cycle per access, driven at the falling edge. The assertions also assume `rst_n` is applied from time zero. The bench holds reset low over the first edges before any access is made.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter logic [15:0] DEV_CODE = 16'h1234,
  parameter logic [15:0] MFR_CODE = 16'hC3A5,
  parameter logic [7:0] REV_CODE = 8'h01,
  parameter logic [7:0] WIN_BASE = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        dev_sel,
  output logic [7:0]        dev_reg,
  output logic [7:0]        dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [7:0]        dev_rdata
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_SEL   = 8'h07;

  logic       unlocked, key_half;
  logic [7:0] idx_q, sel_q, glob_rd;

  wire idx_hit  = io_addr == BASE_ADDR;
  wire data_hit = io_addr == DATA_ADDR;
  wire in_win   = idx_q >= WIN_BASE;
  wire idx_wr   = io_wr & idx_hit;
  wire data_wr  = io_wr & data_hit & unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      key_half <= 1'b0;
      idx_q    <= 8'h00;
      sel_q    <= 8'h00;
    end else begin
      if (idx_wr) begin
        if (!unlocked) begin
          if (io_wdata == KEY_OPEN) begin
            unlocked <= key_half;
            key_half <= ~key_half;
          end else begin
            key_half <= 1'b0;
          end
        end else if (io_wdata == KEY_CLOSE) begin
          unlocked <= 1'b0;
          key_half <= 1'b0;
        end else begin
          idx_q <= io_wdata;
        end
      end
      if (data_wr && idx_q == IDX_SEL) sel_q <= io_wdata;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_SEL: glob_rd = sel_q;
      8'h20:   glob_rd = DEV_CODE[15:8];
      8'h21:   glob_rd = DEV_CODE[7:0];
      8'h22:   glob_rd = REV_CODE;
      8'h23:   glob_rd = MFR_CODE[15:8];
      8'h24:   glob_rd = MFR_CODE[7:0];
      default: glob_rd = 8'hFF;
    endcase
  end

  always_comb begin
    if (!unlocked)     io_rdata = 8'hFF;
    else if (idx_hit)  io_rdata = idx_q;
    else if (data_hit) io_rdata = in_win ? dev_rdata : glob_rd;
    else               io_rdata = 8'hFF;
  end

  assign dev_sel   = sel_q;
  assign dev_reg   = idx_q;
  assign dev_wdata = io_wdata;
  assign dev_wr    = data_wr & in_win;
  assign dev_rd    = io_rd & data_hit & unlocked & in_win;
endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter logic [7:0] WIN_BASE = 8'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        dev_sel,
  input logic [7:0]        dev_reg,
  input logic              dev_wr,
  input logic              dev_rd,
  input logic              unlocked,
  input logic              key_half
);
  wire at_idx  = io_addr == BASE_ADDR;
  wire at_data = io_addr == BASE_ADDR + 1'b1;

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && at_data) |=> $stable(dev_sel));

  // R3
  second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && key_half && io_wr && at_idx && io_wdata == 8'h87) |=> unlocked);

  // R4
  key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && at_idx && io_wdata != 8'h87) |=> (!unlocked && !key_half));

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && at_idx && io_wdata == 8'hAA) |=> !unlocked);

  // R9
  wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> (unlocked && dev_reg >= WIN_BASE));

  // R9
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |-> (unlocked && dev_reg >= WIN_BASE));

  // R10
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_idx && !at_data) |=> ($stable(dev_sel) && $stable(dev_reg) && $stable(unlocked)));
endmodule

bind cfg_key_port cfg_key_port_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_BASE(WIN_BASE)
) chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
  .dev_sel(dev_sel), .dev_reg(dev_reg), .dev_wr(dev_wr), .dev_rd(dev_rd),
  .unlocked(unlocked), .key_half(key_half)
);

// File: tb/cfg_key_port_test.sv
`timescale 1ns/1ps
module cfg_key_port_test;
  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0] io_wdata = 0, dev_rdata = 8'h96;
  logic [7:0] io_rdata, dev_sel, dev_reg, dev_wdata;
  logic dev_wr, dev_rd;
  int total = 0, bad = 0;
  logic done = 0;

  localparam logic [15:0] IDXP = 16'h002E, DATP = 16'h002F;

  cfg_key_port uut (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_sel(dev_sel), .dev_reg(dev_reg),
    .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_rdata(dev_rdata));

  always #4 clk = ~clk;

  // op: 0 index write, 1 data write, 2 data read with expected byte
  localparam int NV = 20;
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 8'h87, 8'h00}, {8'd0, 8'h87, 8'h00},
    {8'd0, 8'h20, 8'h00}, {8'd2, 8'h00, 8'h12},
    {8'd0, 8'h21, 8'h00}, {8'd2, 8'h00, 8'h34},
    {8'd0, 8'h22, 8'h00}, {8'd2, 8'h00, 8'h01},
    {8'd0, 8'h23, 8'h00}, {8'd2, 8'h00, 8'hC3},
    {8'd0, 8'h24, 8'h00}, {8'd2, 8'h00, 8'hA5},
    {8'd0, 8'h07, 8'h00}, {8'd1, 8'h03, 8'h00},
    {8'd2, 8'h00, 8'h03}, {8'd0, 8'h25, 8'h00},
    {8'd2, 8'h00, 8'hFF}, {8'd0, 8'h10, 8'h00},
    {8'd2, 8'h00, 8'hFF}, {8'd0, 8'h07, 8'h00}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0; io_addr = 16'h0000;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d, output logic strobe);
    @(negedge clk); io_addr = a; io_rd = 1;
    #1 d = io_rdata; strobe = dev_rd;
    @(negedge clk); io_rd = 0; io_addr = 16'h0000;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r; logic s;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check("R1 dev_sel", dev_sel, 8'h00);
    rd(DATP, r, s); check("R1 locked read", r, 8'hFF);
    // R2 locked write to index 0 data has no effect
    wr(DATP, 8'h5A); check("R2 dev_sel", dev_sel, 8'h00);
    rd(DATP, r, s); check("R2 read", r, 8'hFF); check("R2 strobe", {7'd0, s}, 8'h00);
    // R4 broken key: 87, 11, 87 stays locked
    wr(IDXP, 8'h87); wr(IDXP, 8'h11); wr(IDXP, 8'h87);
    rd(IDXP, r, s); check("R4 still locked", r, 8'hFF);
    wr(IDXP, 8'h87);
    rd(IDXP, r, s); check("R3 open after pair", r, 8'h11 & 8'h00);
    // table walk: R3 unlock, R8 identity, R7 select, R11 unused, R6 index
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][23:16])
        8'd0: wr(IDXP, VEC[i][15:8]);
        8'd1: wr(DATP, VEC[i][15:8]);
        default: begin rd(DATP, r, s); check("R8/R7/R11 table read", r, VEC[i][7:0]); end
      endcase
    end
    check("R7 dev_sel", dev_sel, 8'h03);
    rd(IDXP, r, s); check("R6 index readback", r, 8'h07);
    check("R6 dev_reg", dev_reg, 8'h07);
    // R10 foreign address ignored
    wr(16'h0080, 8'h55); wr(16'h004E, 8'hAA);
    check("R10 dev_sel", dev_sel, 8'h03);
    rd(DATP, r, s); check("R10 still open", r, 8'h03);
    // R9 window write and read
    wr(IDXP, 8'h40);
    @(negedge clk); io_addr = DATP; io_wdata = 8'h5C; io_wr = 1;
    #1 check("R9 dev_wr", {7'd0, dev_wr}, 8'h01);
    check("R9 dev_wdata", dev_wdata, 8'h5C);
    check("R9 dev_reg", dev_reg, 8'h40);
    @(negedge clk); io_wr = 0; io_addr = 0;
    rd(DATP, r, s); check("R9 read data", r, 8'h96); check("R9 dev_rd", {7'd0, s}, 8'h01);
    // R9 no strobe below window
    wr(IDXP, 8'h22);
    rd(DATP, r, s); check("R9 no rd strobe", {7'd0, s}, 8'h00);
    // R5 relock
    wr(IDXP, 8'hAA);
    rd(DATP, r, s); check("R5 locked read", r, 8'hFF);
    wr(DATP, 8'h09);
    wr(IDXP, 8'h87); wr(IDXP, 8'h87); wr(IDXP, 8'h07);
    rd(DATP, r, s); check("R2 select kept", r, 8'h03);
    // R1 reset again clears select
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    check("R1 reset dev_sel", dev_sel, 8'h00);
    rd(DATP, r, s); check("R1 relocked", r, 8'hFF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule